// File: doc/BRIEF.md
# Parity-Sampled Entropy Combiner with Pair Debiasing

This block takes a wide bundle of free-running oscillator lines and folds them into one raw bit per cycle by computing their parity (modulo-2 sum). The raw bit is not taken on a fixed schedule. A second, independent oscillator drives a sample strobe, and a raw bit is taken once each time that strobe goes from low to high. The lanes and the strobe arrive asynchronously, so each passes through a two-flop synchronizer before it is used.

The captured bits then go to a pairwise debiasing stage. Captures are grouped into consecutive, non-overlapping pairs. Pairs with equal bits are thrown away and counted. Pairs with unequal bits release their first bit on a one-cycle `out_valid` strobe. An enable input halts pair collection without losing a pair that is half built. A synchronous reset clears the half-built pair and the drop counter. The drop counter saturates and is available to a health monitor.

Top module: `xor_debias_sampler`

## Requirements
- R1: While and directly after synchronous reset (`rst_n` low), `out_valid` is 0 and `drop_count` is 0.
- R2: The raw bit is the parity of all `LANES` lane inputs: 1 when an odd number of lanes are high, 0 otherwise. This includes all lanes high (115 ones, parity 1) and all lanes low.
- R3: Exactly one raw bit is captured per low-to-high transition of the synchronized strobe, however long the strobe stays high.
- R4: A pair of equal captured bits (00 or 11) produces no output and increments `drop_count` by one.
- R5: A pair of unequal captured bits (01 or 10) produces one output with `out_bit` equal to the first captured bit of the pair.
- R6: `out_valid` is high for exactly one clock cycle per emitted bit.
- R7: Strobe edges that arrive while `en` is low are ignored. A half-collected pair is kept and is completed by the next capture after `en` returns high.
- R8: Synchronous reset discards a half-collected pair, so the next two captures form a new pair.
- R9: `drop_count` stops at its maximum value, 2^CNT_W-1 (255 by default), and does not wrap.
- R10: Without a strobe rising edge, no output is produced and `drop_count` does not change, whatever the lanes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Allows capture and pair collection when high |
| lanes_i | input | LANES (115) | Asynchronous free-running oscillator lines |
| strobe_i | input | 1 | Asynchronous sample strobe from the sampling oscillator |
| out_valid | output | 1 | One-cycle pulse marking an emitted bit |
| out_bit | output | 1 | Debiased output bit, meaningful when `out_valid` is high |
| drop_count | output | CNT_W (8) | Saturating count of discarded equal pairs |

## Verification
The hardest condition to reach from the ports is a strobe that stays high while the lanes keep changing under it, since only the rising edge may take a sample. The bench holds the strobe high for many cycles, changes lane parity partway through, and then checks that the pair closes with the value from the edge. A second hard case is a pair left half built across an enable-low window or a reset. The bench sets this up by issuing exactly one capture and then applying the disturbance. Saturation of the drop counter is reached by feeding more than 255 equal pairs in a row.

// File: rtl/xds_pkg.sv
package xds_pkg;
  typedef enum logic {
    PAIR_EMPTY = 1'b0,
    PAIR_HALF  = 1'b1
  } pair_st_t;

  function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/xds_sync.sv
module xds_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xds_xor_tree.sv
module xds_xor_tree #(
  parameter int LANES = 115,
  parameter int GROUP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lanes,
  output logic             raw_q
);
  localparam int GROUPS = int'(xds_pkg::ceil_div(LANES, GROUP));

  logic [GROUPS-1:0] part;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = g * GROUP;
    localparam int HI = (LO + GROUP - 1 < LANES) ? LO + GROUP - 1 : LANES - 1;
    assign part[g] = ^lanes[HI:LO];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= ^part;
  end
endmodule

// File: rtl/xds_strobe_edge.sv
module xds_strobe_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_async,
  output logic rise
);
  logic strobe_s;
  logic strobe_prev;

  xds_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_async), .q(strobe_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_prev <= 1'b0;
    else        strobe_prev <= strobe_s;
  end

  assign rise = strobe_s & ~strobe_prev;

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/xds_pair_extract.sv
module xds_pair_extract #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  input  logic             raw,
  output logic             out_valid,
  output logic             out_bit,
  output logic [CNT_W-1:0] drop_count
);
  import xds_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  pair_st_t st;
  logic     first_bit;
  logic     capture;
  logic     pair_close;
  logic     pair_unequal;

  assign capture      = rise & en;
  assign pair_close   = capture & (st == PAIR_HALF);
  assign pair_unequal = first_bit ^ raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= PAIR_EMPTY;
      first_bit  <= 1'b0;
      out_valid  <= 1'b0;
      out_bit    <= 1'b0;
      drop_count <= '0;
    end else begin
      out_valid <= 1'b0;
      if (capture) begin
        if (st == PAIR_EMPTY) begin
          st        <= PAIR_HALF;
          first_bit <= raw;
        end else begin
          st <= PAIR_EMPTY;
          if (pair_unequal) begin
            out_valid <= 1'b1;
            out_bit   <= first_bit;
          end else begin
            drop_count <= sat_inc(drop_count);
          end
        end
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_EMIT_EMPTIES_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> st == PAIR_EMPTY); // R5
  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(st) && $stable(first_bit)); // R7
  AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count == CNT_MAX |=> drop_count == CNT_MAX); // R9
  AST_DROP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count != $past(drop_count) |-> drop_count == $past(drop_count) + 1'b1); // R4
endmodule

// File: rtl/xor_debias_sampler.sv
module xor_debias_sampler #(
  parameter int LANES       = 115,
  parameter int GROUP       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LANES-1:0] lanes_i,
  input  logic             strobe_i,
  output logic             out_valid,
  output logic             out_bit,
  output logic [CNT_W-1:0] drop_count
);
  logic [LANES-1:0] lanes_s;
  logic             raw_q;
  logic             strobe_rise;
  logic             capture_evt;

  xds_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_lane_sync (
    .clk(clk), .rst_n(rst_n), .d(lanes_i), .q(lanes_s)
  );

  xds_xor_tree #(.LANES(LANES), .GROUP(GROUP)) u_tree (
    .clk(clk), .rst_n(rst_n), .lanes(lanes_s), .raw_q(raw_q)
  );

  xds_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_async(strobe_i), .rise(strobe_rise)
  );

  xds_pair_extract #(.CNT_W(CNT_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(strobe_rise), .raw(raw_q),
    .out_valid(out_valid), .out_bit(out_bit), .drop_count(drop_count)
  );

  assign capture_evt = strobe_rise & en;

  AST_OUTPUT_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(capture_evt)); // R10
  AST_DROP_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count != $past(drop_count) |-> $past(capture_evt)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid && drop_count == '0); // R1
endmodule

// File: tb/xor_debias_sampler_test.sv
module xor_debias_sampler_test;
  localparam int LANES = 115;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b1;
  logic [LANES-1:0] lanes_i = '0;
  logic             strobe_i = 1'b0;
  logic             out_valid;
  logic             out_bit;
  logic [CNT_W-1:0] drop_count;

  int checks = 0;
  int fails = 0;
  int vcount = 0;
  int wide_pulses = 0;
  logic last_bit = 1'b0;
  logic prev_valid = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xor_debias_sampler #(.LANES(LANES), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .lanes_i(lanes_i), .strobe_i(strobe_i),
    .out_valid(out_valid), .out_bit(out_bit), .drop_count(drop_count)
  );

  always @(negedge clk) begin
    if (out_valid) begin
      vcount++;
      last_bit = out_bit;
      if (prev_valid) wide_pulses++;
    end
    prev_valid = out_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [LANES-1:0] make_lanes(input bit par, input int seed);
    logic [LANES-1:0] v;
    int ones = 0;
    for (int i = 0; i < LANES; i++) begin
      v[i] = ((i * 7 + seed * 13) % 5) < 2;
      if (v[i]) ones++;
    end
    if ((ones % 2) != int'(par)) v[seed % LANES] = ~v[seed % LANES];
    return v;
  endfunction

  task automatic take(input logic [LANES-1:0] pat, input int hold);
    lanes_i = pat;
    cyc(4);
    strobe_i = 1'b1;
    cyc(hold);
    strobe_i = 1'b0;
    cyc(5);
  endtask

  task automatic pair(input bit a, input bit b, input int seed, input string req);
    int v0 = vcount;
    int d0 = int'(drop_count);
    take(make_lanes(a, seed), 3);
    take(make_lanes(b, seed + 1), 3);
    if (a != b) begin
      chk(vcount == v0 + 1, req, vcount - v0, 1);
      chk(last_bit == a, req, int'(last_bit), int'(a));
      chk(int'(drop_count) == d0, req, int'(drop_count), d0);
    end else begin
      chk(vcount == v0, req, vcount - v0, 0);
      chk(int'(drop_count) == d0 + 1, req, int'(drop_count), d0 + 1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(3);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(drop_count == '0, "R1 count", int'(drop_count), 0);
    rst_n = 1'b1;
    cyc(1);
    chk(drop_count == '0, "R1 count after", int'(drop_count), 0);
  endtask

  task automatic t_pairs();
    pair(1'b0, 1'b1, 3, "R5 01");
    pair(1'b1, 1'b0, 8, "R5 10");
    pair(1'b0, 1'b0, 11, "R4 00");
    pair(1'b1, 1'b1, 20, "R4 11");
  endtask

  task automatic t_parity();
    int v0 = vcount;
    take('1, 3);
    take('0, 3);
    chk(vcount == v0 + 1, "R2 all-ones count", vcount - v0, 1);
    chk(last_bit == 1'b1, "R2 all-ones parity", int'(last_bit), 1);
    v0 = vcount;
    take({{(LANES-2){1'b0}}, 2'b11}, 3);
    take({1'b1, {(LANES-1){1'b0}}}, 3);
    chk(vcount == v0 + 1, "R2 weight2/1 count", vcount - v0, 1);
    chk(last_bit == 1'b0, "R2 weight2 parity", int'(last_bit), 0);
  endtask

  task automatic t_long_strobe();
    int v0 = vcount;
    lanes_i = make_lanes(1'b1, 5);
    cyc(4);
    strobe_i = 1'b1;
    cyc(6);
    for (int k = 0; k < 10; k++) begin
      lanes_i = make_lanes(k[0], 30 + k);
      cyc(4);
    end
    strobe_i = 1'b0;
    cyc(5);
    take(make_lanes(1'b0, 41), 3);
    chk(vcount == v0 + 1, "R3 one capture per edge", vcount - v0, 1);
    chk(last_bit == 1'b1, "R3 edge value", int'(last_bit), 1);
    chk(wide_pulses == 0, "R6 pulse width", wide_pulses, 0);
  endtask

  task automatic t_enable();
    int v0 = vcount;
    int d0;
    take(make_lanes(1'b0, 50), 3);
    en = 1'b0;
    take(make_lanes(1'b1, 51), 3);
    take(make_lanes(1'b0, 52), 3);
    chk(vcount == v0, "R7 no output while disabled", vcount - v0, 0);
    d0 = int'(drop_count);
    en = 1'b1;
    cyc(2);
    take(make_lanes(1'b1, 53), 3);
    chk(vcount == v0 + 1, "R7 pair kept", vcount - v0, 1);
    chk(last_bit == 1'b0, "R7 kept first bit", int'(last_bit), 0);
    chk(int'(drop_count) == d0, "R7 no drop", int'(drop_count), d0);
  endtask

  task automatic t_reset_half();
    int v0;
    take(make_lanes(1'b1, 60), 3);
    do_reset();
    v0 = vcount;
    take(make_lanes(1'b0, 61), 3);
    take(make_lanes(1'b1, 62), 3);
    chk(vcount == v0 + 1, "R8 fresh pair", vcount - v0, 1);
    chk(last_bit == 1'b0, "R8 first bit after reset", int'(last_bit), 0);
  endtask

  task automatic t_idle();
    int v0 = vcount;
    int d0 = int'(drop_count);
    strobe_i = 1'b0;
    for (int c = 0; c < 400; c++) begin
      cyc(1);
      for (int i = 0; i < LANES; i++)
        if (c % (3 + 2 * (i % 3)) == 0) lanes_i[i] = ~lanes_i[i];
    end
    cyc(5);
    chk(vcount == v0, "R10 no output without strobe", vcount - v0, 0);
    chk(int'(drop_count) == d0, "R10 count steady", int'(drop_count), d0);
  endtask

  task automatic t_saturate();
    int target = (1 << CNT_W) + 3;
    do_reset();
    for (int p = 0; p < target; p++) begin
      take('0, 2);
      take('0, 2);
      if (p == (1 << CNT_W) - 2)
        chk(int'(drop_count) == (1 << CNT_W) - 1, "R4 count reaches max", int'(drop_count), (1 << CNT_W) - 1);
    end
    chk(int'(drop_count) == (1 << CNT_W) - 1, "R9 saturation", int'(drop_count), (1 << CNT_W) - 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(2);
    t_reset();
    t_pairs();
    t_parity();
    t_long_strobe();
    t_enable();
    t_reset_half();
    t_idle();
    t_saturate();
    chk(wide_pulses == 0, "R6 final pulse width", wide_pulses, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule